// File: doc/BRIEF.md
# Latched Serial-to-Parallel Output Driver

This block turns a serial bit stream into a wide parallel output word. Bits enter a chain of stages on each rising clock edge. A bank of hold registers sits between the stages and the output pins. A serial output taps the final stage, so several of these blocks can be chained in series to drive a wider array.

A latch-enable input decides whether the outputs follow the shift chain or stay frozen. Two level inputs condition every output bit:
- A blanking input, active low.
- A polarity select.

With these two inputs the outputs can be forced all high, forced all low, inverted, or passed through unchanged.

A build parameter sets how chain stages map onto output pins. In forward order, stage 0 drives output bit 0. In reverse order, stage 0 drives output bit N-1. All inputs are synchronous to the clock. The bench drives them away from the rising edge.

Top module: `serpar_drv`

## Requirements
- R1: A synchronous active-low reset clears every shift stage and every hold bit to 0. After reset, with blanking high and polarity high, the parallel output reads all zeros and the serial output reads 0.
- R2: On each rising clock edge outside reset, stage 0 takes the serial input and stage k takes the old value of stage k-1.
- R3: The serial output always equals the last stage (N-1). It therefore shows the serial input as it was N rising edges earlier.
- R4: The shift chain advances the same way whatever the values of latch enable, blanking and polarity.
- R5: While latch enable is high, the hold bank is transparent. The outputs reflect the shift chain contents in the same cycle.
- R6: While latch enable is low, the hold bank keeps the chain contents left after the last rising edge at which latch enable was high. Further shifting does not reach the outputs.
- R7: Blanking low with polarity low drives all N outputs to 1, regardless of the held data.
- R8: Blanking low with polarity high drives all N outputs to 0, regardless of the held data.
- R9: Blanking high with polarity high makes each output equal its held bit.
- R10: Blanking high with polarity low makes each output the inverse of its held bit.
- R11: In forward order, stage j drives output bit j. In reverse order, stage j drives output bit N-1-j. The serial output taps stage N-1 in both orders.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sdin | input | 1 | Serial data into stage 0 |
| le | input | 1 | Latch enable: high is transparent, low holds |
| blank_n | input | 1 | Blanking, active low: forces outputs to the inverse of pol |
| pol | input | 1 | Polarity: high passes data, low inverts it |
| sdout | output | 1 | Copy of the last stage, for chaining |
| dout | output | N | Conditioned parallel outputs |

## Verification
The bench runs a forward and a reverse instance side by side, so an unmirrored reverse map shows up at once.

Latch enable is pulsed for a single cycle and then held low while more bits shift in. This catches a hold bank that captures one edge late, or one that stays transparent.

The blanking and polarity inputs are changed mid-cycle with no clock edge. A design that registered them, or swapped the meaning of blanking polarity, would show stale or wrong levels.

Bits keep streaming while latch enable, blanking and polarity toggle at random. Any gating of the shift chain by those inputs would therefore corrupt the serial output.

// File: rtl/serpar_pkg.sv
package serpar_pkg;
    // Ordering of chain stages onto the parallel output bits
    typedef enum logic {
        DIR_FWD = 1'b0,
        DIR_REV = 1'b1
    } dir_e;

    localparam int unsigned DEF_STAGES = 32;
endpackage

// File: rtl/serpar_shreg.sv
module serpar_shreg #(
    parameter int unsigned N = serpar_pkg::DEF_STAGES
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sdin,
    output logic [N-1:0] stage_q,
    output logic [N-1:0] stage_d
);
    typedef struct packed {
        logic [N-1:0] stage;
    } sr_state_t;

    sr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d.stage = '0;
        end else begin
            st_d.stage = {st_q.stage[N-2:0], sdin};
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign stage_q = st_q.stage;
    assign stage_d = st_d.stage;
endmodule

// File: rtl/serpar_hold.sv
module serpar_hold #(
    parameter int unsigned N = serpar_pkg::DEF_STAGES
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         le,
    input  logic [N-1:0] chain_cur,
    input  logic [N-1:0] chain_nxt,
    output logic [N-1:0] held
);
    typedef struct packed {
        logic [N-1:0] bits;
    } hold_state_t;

    hold_state_t hs_d, hs_q;

    always_comb begin
        hs_d = hs_q;
        if (!rst_n) begin
            hs_d.bits = '0;
        end else if (le) begin
            // track what the chain will hold after this edge
            hs_d.bits = chain_nxt;
        end
    end

    always_ff @(posedge clk) begin
        hs_q <= hs_d;
    end

    // transparent while enabled, frozen otherwise
    assign held = le ? chain_cur : hs_q.bits;
endmodule

// File: rtl/serpar_outmux.sv
module serpar_outmux #(
    parameter int unsigned     N   = serpar_pkg::DEF_STAGES,
    parameter serpar_pkg::dir_e DIR = serpar_pkg::DIR_FWD
) (
    input  logic [N-1:0] held,
    input  logic         blank_n,
    input  logic         pol,
    output logic [N-1:0] dout
);
    logic [N-1:0] mapped;

    for (genvar i = 0; i < N; i++) begin : g_map
        localparam int unsigned SRC = (DIR == serpar_pkg::DIR_REV) ? (N - 1 - i) : i;
        assign mapped[i] = held[SRC];
    end

    always_comb begin
        if (!blank_n) begin
            dout = pol ? '0 : '1;
        end else if (pol) begin
            dout = mapped;
        end else begin
            dout = ~mapped;
        end
    end
endmodule

// File: rtl/serpar_drv.sv
module serpar_drv #(
    parameter int unsigned     N   = serpar_pkg::DEF_STAGES,
    parameter serpar_pkg::dir_e DIR = serpar_pkg::DIR_FWD
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sdin,
    input  logic         le,
    input  logic         blank_n,
    input  logic         pol,
    output logic         sdout,
    output logic [N-1:0] dout
);
    logic [N-1:0] stage_q;
    logic [N-1:0] stage_d;
    logic [N-1:0] held;

    serpar_shreg #(.N(N)) u_shreg (
        .clk     (clk),
        .rst_n   (rst_n),
        .sdin    (sdin),
        .stage_q (stage_q),
        .stage_d (stage_d)
    );

    serpar_hold #(.N(N)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .le        (le),
        .chain_cur (stage_q),
        .chain_nxt (stage_d),
        .held      (held)
    );

    serpar_outmux #(.N(N), .DIR(DIR)) u_outmux (
        .held    (held),
        .blank_n (blank_n),
        .pol     (pol),
        .dout    (dout)
    );

    assign sdout = stage_q[N-1];
endmodule

// File: rtl/serpar_drv_chk.sv
module serpar_drv_chk #(
    parameter int unsigned     N   = serpar_pkg::DEF_STAGES,
    parameter serpar_pkg::dir_e DIR = serpar_pkg::DIR_FWD
) (
    input logic         clk,
    input logic         rst_n,
    input logic         sdin,
    input logic         le,
    input logic         blank_n,
    input logic         pol,
    input logic         sdout,
    input logic [N-1:0] dout,
    input logic [N-1:0] stage_q
);
    localparam bit REV = (DIR == serpar_pkg::DIR_REV);

    logic tap_bit;
    assign tap_bit = REV ? dout[0] : dout[N-1];

    // R1: reset empties the chain
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (stage_q == '0));

    // R2: stage 0 takes the serial input
    a_r2_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (stage_q[0] == $past(sdin)));

    // R3: the serial output moves one stage per edge
    a_r3_cascade: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (sdout == $past(stage_q[N-2])));

    // R5 and R11: transparent, true polarity, the last stage shows at its pin
    a_r5_transparent: assert property (@(posedge clk) disable iff (!rst_n)
        (le && blank_n && pol) |-> (tap_bit == sdout));

    // R6: hold bank frozen while enable stays low
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !le && !$past(le) && blank_n && pol
         && $past(blank_n) && $past(pol)) |-> $stable(dout));

    // R7: forced all high
    a_r7_all_on: assert property (@(posedge clk) disable iff (!rst_n)
        (!blank_n && !pol) |-> (dout == '1));

    // R8: forced all low
    a_r8_all_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!blank_n && pol) |-> (dout == '0));

    // R10: inverted view of the last stage while transparent
    a_r10_invert: assert property (@(posedge clk) disable iff (!rst_n)
        (le && blank_n && !pol) |-> (tap_bit == !sdout));
endmodule

bind serpar_drv serpar_drv_chk #(.N(N), .DIR(DIR)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sdin    (sdin),
    .le      (le),
    .blank_n (blank_n),
    .pol     (pol),
    .sdout   (sdout),
    .dout    (dout),
    .stage_q (stage_q)
);

// File: tb/serpar_drv_bench.sv
module serpar_drv_bench;
    localparam int unsigned N = 32;

    logic clk = 1'b0;
    logic rst_n, sdin, le, blank_n, pol;
    logic         sdout_f, sdout_r;
    logic [N-1:0] dout_f, dout_r;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [N-1:0] m_sr, m_hold;

    always #2 clk = ~clk;

    serpar_drv #(.N(N), .DIR(serpar_pkg::DIR_FWD)) u_serpar_drv (
        .clk(clk), .rst_n(rst_n), .sdin(sdin), .le(le),
        .blank_n(blank_n), .pol(pol), .sdout(sdout_f), .dout(dout_f)
    );

    serpar_drv #(.N(N), .DIR(serpar_pkg::DIR_REV)) u_serpar_drv_rev (
        .clk(clk), .rst_n(rst_n), .sdin(sdin), .le(le),
        .blank_n(blank_n), .pol(pol), .sdout(sdout_r), .dout(dout_r)
    );

    function automatic logic [N-1:0] mirror(input logic [N-1:0] v);
        logic [N-1:0] r;
        for (int i = 0; i < N; i++) r[i] = v[N-1-i];
        return r;
    endfunction

    function automatic logic [N-1:0] expect_out(input logic rev);
        logic [N-1:0] lat;
        lat = le ? m_sr : m_hold;
        if (rev) lat = mirror(lat);
        if (!blank_n) return pol ? '0 : '1;
        return pol ? lat : ~lat;
    endfunction

    function automatic string mode_tag();
        if (!blank_n) return pol ? "R8" : "R7";
        return pol ? "R9" : "R10";
    endfunction

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk(tag, dout_f, expect_out(1'b0));
        chk({tag, "/R11"}, dout_r, expect_out(1'b1));
        chk("R3", {{(N-1){1'b0}}, sdout_f}, {{(N-1){1'b0}}, m_sr[N-1]});
        chk("R11", {{(N-1){1'b0}}, sdout_r}, {{(N-1){1'b0}}, m_sr[N-1]});
    endtask

    // one clock: inputs set at the falling edge, model advanced at the rising edge
    task automatic step(input logic d, input logic l, input logic b, input logic p);
        @(negedge clk);
        sdin = d; le = l; blank_n = b; pol = p;
        @(posedge clk);
        if (!rst_n) begin
            m_sr = '0; m_hold = '0;
        end else begin
            m_sr = {m_sr[N-2:0], d};
            if (l) m_hold = m_sr;
        end
        #1;
    endtask

    task automatic load_word(input logic [N-1:0] w, input logic l);
        for (int i = N - 1; i >= 0; i--) step(w[i], l, 1'b1, 1'b1);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        m_sr = '0; m_hold = '0;
        rst_n = 1'b0; sdin = 1'b1; le = 1'b1; blank_n = 1'b1; pol = 1'b1;
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b1, 1'b1);
        chk("R1", dout_f, '0);
        chk("R1", {{(N-1){1'b0}}, sdout_f}, '0);
        rst_n = 1'b1;

        // R2 R5 R9: transparent load shows the word right away
        load_word(32'hA5C3_0F96, 1'b1);
        chk("R2/R5", dout_f, 32'hA5C3_0F96);
        chk("R11", dout_r, mirror(32'hA5C3_0F96));

        // R6: freeze, then shift a different word
        load_word(32'h1234_5678, 1'b0);
        chk("R6", dout_f, 32'hA5C3_0F96);
        chk("R3", {{(N-1){1'b0}}, sdout_f}, {{(N-1){1'b0}}, 1'b0});

        // R5 then R6: a one-cycle enable pulse captures 32'h1234_5678 shifted once
        step(1'b1, 1'b1, 1'b1, 1'b1);
        chk("R5", dout_f, {32'h1234_5678, 1'b1} & '1);
        for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 1'b1, 1'b1);
        chk("R6", dout_f, 32'h2468_ACF1);

        // R7..R10: change the modes mid-cycle, no clock edge
        @(negedge clk); blank_n = 1'b0; pol = 1'b0; #1;
        chk("R7", dout_f, '1);
        blank_n = 1'b0; pol = 1'b1; #1;
        chk("R8", dout_f, '0);
        blank_n = 1'b1; pol = 1'b0; #1;
        chk("R10", dout_f, ~32'h2468_ACF1);
        blank_n = 1'b1; pol = 1'b1; #1;
        chk("R9", dout_f, 32'h2468_ACF1);

        // R4: shift a word while the controls toggle, then expose it
        for (int i = N - 1; i >= 0; i--)
            step(32'hDEAD_BEEF >> i, 1'b0, i[0], i[1]);
        step(1'b0, 1'b1, 1'b1, 1'b1);
        chk("R4", dout_f, {32'hDEAD_BEEF, 1'b0} & '1);

        // random traffic against the model
        for (int i = 0; i < 600; i++) begin
            step(1'($urandom), ($urandom % 5) == 0, ($urandom % 4) != 0, 1'($urandom));
            check_all(mode_tag());
        end

        // R1: reset in mid-run
        rst_n = 1'b0;
        step(1'b1, 1'b1, 1'b1, 1'b1);
        rst_n = 1'b1;
        chk("R1", dout_f, '0);
        chk("R1", dout_r, '0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule